// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data ports, A and B, each modelled as a data input vector, a data output vector and one common output enable. It carries data in both directions without inversion. Each direction has a storage register. The A-to-B register samples port A on a rising edge of its capture strobe, and the B-to-A register samples port B on a rising edge of its own strobe. A source select for each direction decides whether the driving port shows live data from the opposite port or the word stored for that direction.

Two enables decide which ports drive. The B drive enable is active high and the A drive enable is active low. The strobes are treated as synchronous to one system clock and are edge-detected inside the block.

When both ports drive and both selects choose live data, the block is in bus-hold mode. Each port's output drives that port's own value as resolved on the previous system clock. With no other driver on either bus, each bus therefore keeps its last value. This per-port hold is registered, so it adds no combinational loop through the two ports.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero. A strobe that is held high while reset is asserted does not cause a capture after reset is released.
- R2: At a system clock edge where `cap_ab` is high and was low on the previous edge, the A-to-B register loads `a_in`. On every other edge it keeps its value, including when `cap_ab` stays high.
- R3: At a system clock edge where `cap_ba` is high and was low on the previous edge, the B-to-A register loads `b_in`. On every other edge it keeps its value.
- R4: Captures take place whatever the levels of `src_ab`, `src_ba`, `drv_b` and `drv_a_n`.
- R5: Outside bus-hold mode, `b_out` equals `a_in` when `src_ab` is 0 and equals the A-to-B register when `src_ab` is 1. All W bits pass through without inversion.
- R6: Outside bus-hold mode, `a_out` equals `b_in` when `src_ba` is 0 and equals the B-to-A register when `src_ba` is 1. All W bits pass through without inversion.
- R7: `a_oe` is 1 exactly when `drv_a_n` is 0, and `b_oe` is 1 exactly when `drv_b` is 1. The four enable combinations give: no port driving, A only, B only, or both.
- R8: Bus-hold mode is active when `drv_b`=1, `drv_a_n`=0, `src_ab`=0 and `src_ba`=0. In this mode `a_out` equals `a_in` and `b_out` equals `b_in` as sampled at the previous system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Bus B output enable |
| cap_ab | input | 1 | A-to-B capture strobe, rising edge |
| cap_ba | input | 1 | B-to-A capture strobe, rising edge |
| src_ab | input | 1 | 1 selects the stored word for B, 0 selects live A |
| src_ba | input | 1 | 1 selects the stored word for A, 0 selects live B |
| drv_b | input | 1 | Drive bus B, active high |
| drv_a_n | input | 1 | Drive bus A, active low |

## Verification
The bench sweeps all sixteen combinations of the two enables and the two selects. Before each combination it loads both registers with fresh random words, so that stored data can be told apart from live data. Within each combination, external drivers feed random words onto every port the block is not driving, which separates a live path from a stale one. The strobes are pulsed inside each combination, and the bench then reads the stored words back; this shows that captures ignore the mode pins. In bus-hold mode every external driver is released, and the bench checks that each bus keeps its own previous value rather than the value of the other port. It also holds a strobe high through reset and afterwards to separate a level capture from an edge capture.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         src_ab,
  input  logic         src_ba,
  input  logic         drv_b,
  input  logic         drv_a_n
);

  logic [W-1:0] store_ab, store_ba, keep_a, keep_b;
  logic         last_ab, last_ba;
  logic         hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_ab <= '0;
      store_ba <= '0;
      keep_a   <= '0;
      keep_b   <= '0;
      last_ab  <= 1'b1;
      last_ba  <= 1'b1;
    end else begin
      last_ab <= cap_ab;
      last_ba <= cap_ba;
      keep_a  <= a_in;
      keep_b  <= b_in;
      if (cap_ab && !last_ab) store_ab <= a_in;
      if (cap_ba && !last_ba) store_ba <= b_in;
    end
  end

  assign a_oe  = !drv_a_n;
  assign b_oe  = drv_b;
  assign hold  = a_oe && b_oe && !src_ab && !src_ba;
  assign a_out = hold ? keep_a : (src_ba ? store_ba : b_in);
  assign b_out = hold ? keep_b : (src_ab ? store_ab : a_in);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store_ab == '0 && store_ba == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_ab && !$past(cap_ab) && !$past(rst)) |=> (store_ab == $past(a_in)));

  a_r2_keep: assert property (@(posedge clk) disable iff (rst)
    !(cap_ab && !$past(cap_ab)) |=> $stable(store_ab));

  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_ba && !$past(cap_ba) && !$past(rst)) |=> (store_ba == $past(b_in)));

  a_r3_keep: assert property (@(posedge clk) disable iff (rst)
    !(cap_ba && !$past(cap_ba)) |=> $stable(store_ba));

  a_r8_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (hold && !$past(rst)) |-> (a_out == $past(a_in) && b_out == $past(b_in)));

endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [W-1:0] a_ext, b_ext;
  logic         a_ext_en, b_ext_en;
  logic [W-1:0] a_out, b_out;
  wire  [W-1:0] a_in, b_in;
  logic         a_oe, b_oe;
  logic         cap_ab = 0, cap_ba = 0, src_ab = 0, src_ba = 0, drv_b = 0, drv_a_n = 1;

  assign a_in = a_ext_en ? a_ext : (a_oe ? a_out : '0);
  assign b_in = b_ext_en ? b_ext : (b_oe ? b_out : '0);

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .src_ab(src_ab), .src_ba(src_ba),
    .drv_b(drv_b), .drv_a_n(drv_a_n)
  );

  logic [W-1:0] m_ab, m_ba, m_ka, m_kb;
  logic         m_pab, m_pba;
  always @(posedge clk) begin
    if (rst) begin
      m_ab <= '0; m_ba <= '0; m_ka <= '0; m_kb <= '0; m_pab <= 1; m_pba <= 1;
    end else begin
      m_pab <= cap_ab; m_pba <= cap_ba;
      m_ka <= a_in; m_kb <= b_in;
      if (cap_ab && !m_pab) m_ab <= a_in;
      if (cap_ba && !m_pba) m_ba <= b_in;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    bit hold;
    logic [W-1:0] ea, eb;
    hold = !drv_a_n && drv_b && !src_ab && !src_ba;
    ea = hold ? m_ka : (src_ba ? m_ba : b_in);
    eb = hold ? m_kb : (src_ab ? m_ab : a_in);
    cmp("R7 a_oe", W'(a_oe), W'(!drv_a_n));
    cmp("R7 b_oe", W'(b_oe), W'(drv_b));
    cmp(hold ? "R8 a_out" : (src_ba ? "R3/R6 a_out" : "R6 a_out"), a_out, ea);
    cmp(hold ? "R8 b_out" : (src_ab ? "R2/R5 b_out" : "R5 b_out"), b_out, eb);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ext();
    a_ext_en = !a_oe || !(!drv_a_n);
    b_ext_en = !drv_b;
    a_ext_en = drv_a_n;
    a_ext = W'($urandom);
    b_ext = W'($urandom);
  endtask

  initial begin
    a_ext = 8'h5a; b_ext = 8'ha5; a_ext_en = 1; b_ext_en = 1;
    cap_ab = 1; cap_ba = 1;
    repeat (3) cyc();
    rst = 0;
    cyc(); cyc();
    src_ab = 1; src_ba = 1; drv_b = 1; drv_a_n = 0;
    a_ext_en = 0; b_ext_en = 0;
    #1;
    cmp("R1 stored A-to-B after reset", b_out, '0);
    cmp("R1 stored B-to-A after reset", a_out, '0);
    cap_ab = 0; cap_ba = 0;

    for (int combo = 0; combo < 16; combo++) begin
      drv_b = 0; drv_a_n = 1; src_ab = 1; src_ba = 1;
      a_ext_en = 1; b_ext_en = 1;
      a_ext = W'($urandom); b_ext = W'($urandom);
      cyc();
      cap_ab = 1; cap_ba = 1;
      cyc();
      cap_ab = 0; cap_ba = 0;
      a_ext = W'($urandom); b_ext = W'($urandom);
      #1;
      cmp("R2 loaded word", b_out, m_ab);
      cmp("R3 loaded word", a_out, m_ba);
      drv_b = combo[0]; drv_a_n = combo[1]; src_ab = combo[2]; src_ba = combo[3];
      set_ext();
      for (int k = 0; k < 4; k++) begin
        if (!drv_a_n && drv_b && !src_ab && !src_ba) begin
          a_ext_en = 0; b_ext_en = 0;
        end
        if (k == 1) begin cap_ab = 1; cap_ba = 1; end
        #1;
        check_all();
        cyc();
        check_all();
        if (a_ext_en) a_ext = W'($urandom);
        if (b_ext_en) b_ext = W'($urandom);
      end
      cap_ab = 0; cap_ba = 0;
      drv_b = 1; drv_a_n = 0; src_ab = 1; src_ba = 1;
      a_ext_en = 0; b_ext_en = 0;
      #1;
      cmp("R4 capture under any mode A-to-B", b_out, m_ab);
      cmp("R4 capture under any mode B-to-A", a_out, m_ba);
    end

    drv_b = 0; drv_a_n = 1; src_ab = 1; src_ba = 1;
    a_ext_en = 1; b_ext_en = 1; a_ext = 8'h3c; b_ext = 8'hc3;
    cyc();
    cap_ab = 1; cap_ba = 1;
    cyc();
    a_ext = 8'hff; b_ext = 8'h00;
    cyc(); cyc();
    #1;
    cmp("R2 strobe held high keeps word", b_out, 8'h3c);
    cmp("R3 strobe held high keeps word", a_out, 8'hc3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule